// File: doc/BRIEF.md
# Reset and Oscillator Warm-Up Controller

This block merges every reset cause of a small controller core into one core reset and decides when the oscillator may serve as the core clock. The external reset arrives on a bidirectional pin. It is synchronised and must stay high for a minimum run of cycles before it counts. Power-fail, watchdog and system reset requests are merged, and while any of them is active the block drives the pin high, so that the rest of the board sees the reset too. The pin's own echo is kept out of the input path, so the block cannot hold itself in reset.

A warm-up counter of `WARM_CYCLES` cycles (65,536 by default) keeps the clock-ready flag low after power-up, after an oscillator restart that follows stop mode, after an external reset recognised during stop mode, and after the clock multiplier is enabled. In every case except the multiplier, the count also holds the core in reset until it has finished. The core reset falls one cycle after clock-ready rises, so the clock switch-over comes before the core leaves reset.

Top module: `reset_warmup_ctrl`

## Requirements
- R1: The pin input passes through a two-flop synchroniser. It is recognised only after it has been high at three consecutive clock edges. A pulse that lasts only two cycles never asserts the core reset.
- R2: While a recognised pin reset stays high, the core reset stays high.
- R3: After the pin falls, and with no other cause active, the core reset falls on the fourth clock edge.
- R4: A power-fail, watchdog or system request that is high at an edge sets both the pin drive enable and the core reset from that edge. The drive enable falls on the first edge at which no request is high. The drive enable is never high while the core reset is low.
- R5: While the block drives the pin, the pin input is ignored. The echoed level cannot extend the reset: the core reset falls together with the drive enable.
- R6: While the power-on reset input is high: core reset is 1, clock-ready is 0 and drive enable is 0. After it falls, clock-ready rises at the WARM_CYCLES-th edge and core reset falls one edge later.
- R7: A stop-wake pulse clears clock-ready at its edge and holds it low for exactly WARM_CYCLES cycles. The core reset is high from the next edge until one edge after clock-ready rises.
- R8: An external reset recognised while stop mode is high starts the warm-up. The core reset stays high after the pin is released, until one edge after clock-ready rises.
- R9: An external reset recognised outside stop mode leaves clock-ready high.
- R10: A multiplier-enable pulse holds clock-ready low for WARM_CYCLES cycles and leaves the core reset low.
- R11: A new warm-up trigger while a count is running restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Synchronous active-high power-on reset; also starts the warm-up |
| rst_pin_i | input | 1 | Level seen on the bidirectional reset pin |
| rst_pin_oe_o | output | 1 | Drive-high enable for the reset pin |
| pfail_rst_i | input | 1 | Power-fail reset request |
| wdog_rst_i | input | 1 | Watchdog reset request |
| sys_rst_i | input | 1 | Internal system reset request |
| stop_mode_i | input | 1 | High while the core is in stop mode |
| stop_wake_i | input | 1 | One-cycle pulse: oscillator restarted after stop |
| mult_en_i | input | 1 | One-cycle pulse: clock multiplier enabled |
| core_rst_o | output | 1 | Merged core reset |
| clk_ready_o | output | 1 | Oscillator may serve as the core clock |

## Verification
Two functions can meet in one cycle: pin qualification and internal pin drive. A system request is raised while an external reset is already held on the pin. The drive enable must then follow only the internal request, and the core reset must stay high without a gap after the drive ends, because the held pin level keeps the qualified state frozen rather than cleared. A second collision is a warm-up trigger that arrives during a running count. The bench judges it by the exact edge at which clock-ready rises, counted from the second trigger.

// File: rtl/rwc_pkg.sv
package rwc_pkg;

  // Warm-up start request: whether core reset is held and whether the count starts
  typedef struct packed {
    logic hold_core;
    logic start;
  } warm_req_t;

  function automatic warm_req_t make_req(input logic hold_src, input logic clk_src);
    warm_req_t r;
    r.hold_core = hold_src;
    r.start     = hold_src | clk_src;
    return r;
  endfunction

endpackage

// File: rtl/rwc_sync.sv
module rwc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic freeze,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] st;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst)         st[0] <= 1'b0;
          else if (!freeze) st[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) st[g] <= 1'b0;
          else     st[g] <= st[g-1];
        end
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/rwc_qual.sv
module rwc_qual #(
  parameter int QUAL_CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic hit_o,
  output logic rise_o
);
  localparam int RUN_W = $clog2(QUAL_CYCLES + 1);
  localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(QUAL_CYCLES - 1);

  logic [RUN_W-1:0] run;
  logic             hit_q;
  logic             hit_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      run   <= '0;
      hit_q <= 1'b0;
      hit_d <= 1'b0;
    end else begin
      hit_d <= hit_q;
      hit_q <= lvl && (run >= RUN_LIM);
      if (!lvl)                run <= '0;
      else if (run < RUN_LIM)  run <= run + 1'b1;
    end
  end

  assign hit_o  = hit_q;
  assign rise_o = hit_q & ~hit_d;
endmodule

// File: rtl/rwc_warmup.sv
module rwc_warmup
  import rwc_pkg::*;
#(
  parameter int WARM_CYCLES = 65536
) (
  input  logic      clk,
  input  logic      rst,
  input  warm_req_t req,
  output logic      ready_o,
  output logic      hold_o
);
  localparam int CNT_W = (WARM_CYCLES > 1) ? $clog2(WARM_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WARM_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic             ready_q;
  logic             hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      ready_q <= 1'b0;
      hold_q  <= 1'b1;
    end else if (req.start) begin
      cnt     <= '0;
      ready_q <= 1'b0;
      hold_q  <= hold_q | req.hold_core;
    end else if (!ready_q) begin
      if (cnt == LAST) begin
        ready_q <= 1'b1;
        hold_q  <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign ready_o = ready_q;
  assign hold_o  = hold_q;
endmodule

// File: rtl/reset_warmup_ctrl.sv
module reset_warmup_ctrl
  import rwc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CYCLES = 3,
  parameter int WARM_CYCLES = 65536
) (
  input  logic clk,
  input  logic por_i,
  input  logic rst_pin_i,
  output logic rst_pin_oe_o,
  input  logic pfail_rst_i,
  input  logic wdog_rst_i,
  input  logic sys_rst_i,
  input  logic stop_mode_i,
  input  logic stop_wake_i,
  input  logic mult_en_i,
  output logic core_rst_o,
  output logic clk_ready_o
);
  logic      pin_sync;
  logic      ext_hit;
  logic      ext_rise;
  logic      int_any;
  logic      warm_hold;
  logic      oe_q;
  logic      core_q;
  warm_req_t wreq;

  assign int_any = pfail_rst_i | wdog_rst_i | sys_rst_i;

  // Own drive freezes the first sync stage so the echo is never sampled
  rwc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (por_i),
    .freeze (oe_q),
    .d      (rst_pin_i),
    .q      (pin_sync)
  );

  rwc_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
    .clk    (clk),
    .rst    (por_i),
    .lvl    (pin_sync),
    .hit_o  (ext_hit),
    .rise_o (ext_rise)
  );

  assign wreq = make_req(stop_wake_i | (ext_rise & stop_mode_i), mult_en_i);

  rwc_warmup #(.WARM_CYCLES(WARM_CYCLES)) u_warm (
    .clk     (clk),
    .rst     (por_i),
    .req     (wreq),
    .ready_o (clk_ready_o),
    .hold_o  (warm_hold)
  );

  always_ff @(posedge clk) begin
    if (por_i) begin
      oe_q   <= 1'b0;
      core_q <= 1'b1;
    end else begin
      oe_q   <= int_any;
      core_q <= ext_hit | int_any | warm_hold;
    end
  end

  assign rst_pin_oe_o = oe_q;
  assign core_rst_o   = core_q;
endmodule

// File: rtl/rwc_checker.sv
module rwc_checker #(
  parameter int WARM_CYCLES = 65536
) (
  input logic clk,
  input logic por_i,
  input logic pfail_rst_i,
  input logic wdog_rst_i,
  input logic sys_rst_i,
  input logic ext_hit,
  input logic rst_pin_oe_o,
  input logic core_rst_o,
  input logic clk_ready_o
);
  logic [31:0] low_run;

  always_ff @(posedge clk) begin
    if (por_i)              low_run <= '0;
    else if (clk_ready_o)   low_run <= '0;
    else if (low_run != '1) low_run <= low_run + 1'b1;
  end

  assert_oe_needs_rst_R4: assert property (@(posedge clk) disable iff (por_i)
    rst_pin_oe_o |-> core_rst_o);

  assert_int_drives_pin_R4: assert property (@(posedge clk) disable iff (por_i)
    (pfail_rst_i | wdog_rst_i | sys_rst_i) |=> (rst_pin_oe_o && core_rst_o));

  assert_no_stale_drive_R5: assert property (@(posedge clk) disable iff (por_i)
    !(pfail_rst_i | wdog_rst_i | sys_rst_i) |=> !rst_pin_oe_o);

  assert_pin_holds_rst_R2: assert property (@(posedge clk) disable iff (por_i)
    ext_hit |=> core_rst_o);

  assert_full_warmup_R7: assert property (@(posedge clk) disable iff (por_i)
    $rose(clk_ready_o) |-> (low_run >= 32'(WARM_CYCLES)));
endmodule

bind reset_warmup_ctrl rwc_checker #(.WARM_CYCLES(WARM_CYCLES)) u_rwc_checker (
  .clk          (clk),
  .por_i        (por_i),
  .pfail_rst_i  (pfail_rst_i),
  .wdog_rst_i   (wdog_rst_i),
  .sys_rst_i    (sys_rst_i),
  .ext_hit      (ext_hit),
  .rst_pin_oe_o (rst_pin_oe_o),
  .core_rst_o   (core_rst_o),
  .clk_ready_o  (clk_ready_o)
);

// File: tb/reset_warmup_ctrl_bench.sv
`timescale 1ns/1ps
module reset_warmup_ctrl_bench;
  localparam int W = 64;

  logic clk = 1'b0;
  logic por, ext_drive, pfail, wdog, sysr, stop_mode, stop_wake, mult_en;
  logic oe, core_rst, ready;
  logic pin;
  int   n_checks = 0;
  int   n_fails  = 0;
  bit   done     = 1'b0;

  always #2 clk = ~clk;

  assign pin = ext_drive | oe;

  reset_warmup_ctrl #(.WARM_CYCLES(W)) u_reset_warmup_ctrl (
    .clk          (clk),
    .por_i        (por),
    .rst_pin_i    (pin),
    .rst_pin_oe_o (oe),
    .pfail_rst_i  (pfail),
    .wdog_rst_i   (wdog),
    .sys_rst_i    (sysr),
    .stop_mode_i  (stop_mode),
    .stop_wake_i  (stop_wake),
    .mult_en_i    (mult_en),
    .core_rst_o   (core_rst),
    .clk_ready_o  (ready)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input logic got, input logic exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
    end
  endtask

  task automatic test_powerup();
    por = 1'b1;
    tick(5);
    check("R6", "core_rst in por", core_rst, 1'b1);
    check("R6", "ready in por", ready, 1'b0);
    check("R6", "oe in por", oe, 1'b0);
    por = 1'b0;
    tick(W - 1);
    check("R6", "ready before end", ready, 1'b0);
    tick(1);
    check("R6", "ready at end", ready, 1'b1);
    check("R6", "core_rst still held", core_rst, 1'b1);
    tick(1);
    check("R6", "core_rst released", core_rst, 1'b0);
  endtask

  task automatic test_short_pulse();
    ext_drive = 1'b1;
    tick(2);
    ext_drive = 1'b0;
    for (int i = 0; i < 10; i++) begin
      tick(1);
      check("R1", "2-cycle pulse ignored", core_rst, 1'b0);
    end
    ext_drive = 1'b1;
    tick(3);
    ext_drive = 1'b0;
    tick(3);
    check("R1", "3-cycle pulse recognised", core_rst, 1'b1);
    tick(1);
    check("R3", "3-cycle pulse released", core_rst, 1'b0);
  endtask

  task automatic test_hold_release();
    ext_drive = 1'b1;
    tick(20);
    check("R2", "held pin keeps reset", core_rst, 1'b1);
    check("R9", "ready untouched outside stop", ready, 1'b1);
    ext_drive = 1'b0;
    tick(3);
    check("R3", "reset still high 3 edges", core_rst, 1'b1);
    tick(1);
    check("R3", "reset low by 4th edge", core_rst, 1'b0);
  endtask

  task automatic test_internal_drive();
    wdog = 1'b1;
    tick(1);
    check("R4", "oe on watchdog", oe, 1'b1);
    check("R4", "core_rst on watchdog", core_rst, 1'b1);
    tick(5);
    check("R4", "oe held", oe, 1'b1);
    wdog = 1'b0;
    tick(1);
    check("R4", "oe released", oe, 1'b0);
    check("R5", "core_rst falls with oe", core_rst, 1'b0);
    for (int i = 0; i < 8; i++) begin
      tick(1);
      check("R5", "echo not recaptured", core_rst, 1'b0);
    end
    pfail = 1'b1;
    tick(1);
    check("R4", "oe on power-fail", oe, 1'b1);
    pfail = 1'b0;
    tick(1);
    check("R4", "oe off after power-fail", oe, 1'b0);
  endtask

  task automatic test_overlap();
    ext_drive = 1'b1;
    tick(10);
    sysr = 1'b1;
    tick(3);
    check("R4", "oe during overlap", oe, 1'b1);
    sysr = 1'b0;
    for (int i = 0; i < 6; i++) begin
      tick(1);
      check("R2", "no gap after drive ends", core_rst, 1'b1);
    end
    check("R4", "oe follows internal only", oe, 1'b0);
    ext_drive = 1'b0;
    tick(4);
    check("R3", "released after overlap", core_rst, 1'b0);
  endtask

  task automatic test_stop_wake();
    stop_wake = 1'b1;
    tick(1);
    stop_wake = 1'b0;
    check("R7", "ready drops at wake", ready, 1'b0);
    tick(1);
    check("R7", "core_rst held in warm-up", core_rst, 1'b1);
    tick(W - 2);
    check("R7", "ready before end", ready, 1'b0);
    tick(1);
    check("R7", "ready at end", ready, 1'b1);
    check("R7", "core_rst one more edge", core_rst, 1'b1);
    tick(1);
    check("R7", "core_rst released", core_rst, 1'b0);
  endtask

  task automatic test_mult();
    mult_en = 1'b1;
    tick(1);
    mult_en = 1'b0;
    check("R10", "ready drops", ready, 1'b0);
    tick(W / 2);
    check("R10", "core_rst unaffected", core_rst, 1'b0);
    tick(W / 2 - 1);
    check("R10", "ready before end", ready, 1'b0);
    tick(1);
    check("R10", "ready at end", ready, 1'b1);
    check("R10", "core_rst still low", core_rst, 1'b0);
  endtask

  task automatic test_restart();
    stop_wake = 1'b1;
    tick(1);
    stop_wake = 1'b0;
    tick(20);
    stop_wake = 1'b1;
    tick(1);
    stop_wake = 1'b0;
    tick(W - 1);
    check("R11", "count restarted", ready, 1'b0);
    tick(1);
    check("R11", "ready after restart", ready, 1'b1);
    tick(1);
    check("R11", "core_rst released", core_rst, 1'b0);
  endtask

  task automatic test_ext_in_stop();
    int n;
    stop_mode = 1'b1;
    ext_drive = 1'b1;
    tick(12);
    ext_drive = 1'b0;
    tick(8);
    check("R8", "ready low after stop reset", ready, 1'b0);
    check("R8", "core_rst held past pin", core_rst, 1'b1);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      tick(1);
      n++;
      if (ready) break;
    end
    n_checks++;
    if (n != 50) begin
      n_fails++;
      $display("FAIL R8 ready rise edge: got %0d expected %0d", n, 50);
    end
    check("R8", "core_rst at ready", core_rst, 1'b1);
    tick(1);
    check("R8", "core_rst released", core_rst, 1'b0);
    stop_mode = 1'b0;
  endtask

  task automatic test_ext_no_stop();
    ext_drive = 1'b1;
    for (int i = 0; i < 10; i++) begin
      tick(1);
      check("R9", "ready stays high", ready, 1'b1);
    end
    ext_drive = 1'b0;
    tick(6);
    check("R9", "ready still high", ready, 1'b1);
    check("R3", "core_rst released", core_rst, 1'b0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
  endtask

  initial begin
    por = 1'b1; ext_drive = 1'b0; pfail = 1'b0; wdog = 1'b0; sysr = 1'b0;
    stop_mode = 1'b0; stop_wake = 1'b0; mult_en = 1'b0;
    @(negedge clk);
    test_powerup();
    test_short_pulse();
    test_hold_release();
    test_internal_drive();
    test_overlap();
    test_stop_wake();
    test_mult();
    test_restart();
    test_ext_in_stop();
    test_ext_no_stop();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule